// File: doc/BRIEF.md
# Nibble Time-Slot Interchanger

This block moves 4-bit channels between time slots of serial TDM streams. Each input stream runs at 2.048 Mb/s and is cut into 64 nibble slots per frame, so every channel carries 32 kb/s. The block takes in eight serial input streams and drives four serial output streams. It stores every incoming nibble in a memory with two banks. Each output slot then looks up a connection entry that names the source stream and source slot to copy. Every path through the block has the same fixed delay of one frame.

Two sub-modes exist. In the blocking arrangement, a connection entry can name any of the eight inputs, which gives a 512 x 256 nibble matrix. In the non-blocking arrangement, a four-entry table first maps four logical inputs to any four physical streams, which gives a 256 x 256 matrix. Software writes the connection entries, the table and the mode through a simple write port.

Top module: `nibble_tsi`

## Requirements
- R1: Reset sets the following state. Every output is 0 until the first slot boundary. The mode is blocking. Every connection entry selects stream 0, slot 0. Table entry i holds stream i. As a result, with no writes, output frame 1 repeats the frame-0 nibble of stream 0, slot 0 in every slot.
- R2: A frame lasts 512 clocks. Each bit lasts 2 clocks and each nibble slot lasts 8 clocks. fp_i is high on the last clock of a frame. Input bits are sampled on the first clock of each bit period. Within a slot the nibble arrives MSB first.
- R3: In blocking mode, output o in slot s of frame f carries the nibble that arrived on the entry's source stream (3 bits) in the entry's source slot during frame f-1. This holds for any of the 8 inputs.
- R4: Output bits leave MSB first and are aligned to the same frame and slot grid as the inputs. Each bit holds its value for both of its clocks.
- R5: In non-blocking mode, the low two bits of the source-stream field index the input table, and the physical stream comes from that table. Bit 2 of the source-stream field is ignored.
- R6: A write to table entry k sets the physical stream used by logical input k from the next frame on.
- R7: One source nibble may feed several output streams and slots in the same frame.
- R8: Address map. The address is 9 bits and the write data is 9 bits.
  - If addr[8]=0, the write sets the connection entry for output addr[7:6] and slot addr[5:0]. The data holds the source stream in [8:6] and the source slot in [5:0].
  - If addr[8]=1 and addr[2]=0, the write sets the mode from data[0] (1 = non-blocking).
  - If addr[8]=1 and addr[2]=1, the write sets table entry addr[1:0] from data[2:0].
- R9: While wr_en_i is low, the address and data inputs change no state.
- R10: Frame edges cause no errors. Source slot 63 and source slot 0 are copied correctly, and so are output slots 0 and 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 4.096 MHz interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fp_i | input | 1 | Frame pulse, high on the last clock of a frame |
| sti_i | input | 8 | Serial input streams |
| sto_o | output | 4 | Serial output streams |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 9 | Register write address |
| wdata_i | input | 9 | Register write data |

## Verification
The assertions rely on four conditions:
- fp_i arrives exactly once every 512 clocks, on the last clock of the frame.
- Each serial input holds its value across both clocks of a bit.
- A register write lasts exactly one clock.
- Changes to the configuration are allowed to touch the output frame in which they land.

The bench meets these conditions as follows. It drives every input from a single phase counter that starts at reset release and raises fp_i only at phase 511. It issues every write as a one-cycle strobe. It judges an output frame only once a full frame has passed since the last write.

// File: rtl/nts_pkg.sv
`timescale 1ns/1ps
package nts_pkg;
  localparam int NIB_W       = 4;
  localparam int CLK_PER_BIT = 2;
  typedef enum logic {MODE_BLOCK = 1'b0, MODE_NONBLOCK = 1'b1} mode_e;
endpackage

// File: rtl/nts_frame_ctr.sv
`timescale 1ns/1ps
module nts_frame_ctr
  import nts_pkg::*;
#(
  parameter int SLOTS = 64,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int PH_W   = $clog2(CLK_PER_BIT),
  localparam int NB_W   = $clog2(NIB_W),
  localparam int CNT_W  = SLOT_W + NB_W + PH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fp_i,
  output logic              bank_o,
  output logic              smp_o,
  output logic              wr_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [NB_W-1:0]   nbit_o,
  output logic              pref_o,
  output logic [SLOT_W-1:0] pref_slot_o,
  output logic              pref_bank_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bank_q <= 1'b0;
    end else if (fp_i) begin
      cnt_q  <= '0;
      bank_q <= ~bank_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign slot_o = cnt_q[CNT_W-1 -: SLOT_W];
  assign nbit_o = cnt_q[PH_W +: NB_W];
  assign smp_o  = (cnt_q[PH_W-1:0] == '0);
  assign wr_o   = smp_o && (nbit_o == '1);
  assign bank_o = bank_q;

  // last clock of a slot, or frame end: fetch next slot; at frame end the fresh bank
  assign pref_o      = fp_i || (cnt_q[PH_W+NB_W-1:0] == '1);
  assign pref_slot_o = fp_i ? '0 : slot_o + 1'b1;
  assign pref_bank_o = fp_i ? bank_q : ~bank_q;

  p_frame_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_i |=> (cnt_q == '0));
  p_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fp_i |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_swap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_i |=> (bank_q != $past(bank_q)));
  p_bank_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fp_i |=> $stable(bank_q));
endmodule

// File: rtl/nts_rx.sv
`timescale 1ns/1ps
module nts_rx
  import nts_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_OUT = 4,
  parameter int SLOTS = 64,
  localparam int IN_W   = $clog2(N_IN),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [N_IN-1:0]                  sti_i,
  input  logic                             smp_i,
  input  logic                             wr_i,
  input  logic                             bank_i,
  input  logic [SLOT_W-1:0]                slot_i,
  input  logic                             rd_bank_i,
  input  logic [N_OUT-1:0][IN_W-1:0]       rd_st_i,
  input  logic [N_OUT-1:0][SLOT_W-1:0]     rd_sl_i,
  output logic [N_OUT-1:0][NIB_W-1:0]      rd_nib_o
);
  logic [N_IN-1:0][NIB_W-2:0] sr_q;
  logic [NIB_W-1:0]           mem_q [N_IN][2*SLOTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (smp_i) begin
      for (int i = 0; i < N_IN; i++) sr_q[i] <= {sr_q[i][NIB_W-3:0], sti_i[i]};
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      for (int i = 0; i < N_IN; i++) mem_q[i][{bank_i, slot_i}] <= {sr_q[i], sti_i[i]};
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_rd
    assign rd_nib_o[o] = mem_q[rd_st_i[o]][{rd_bank_i, rd_sl_i[o]}];
  end

  p_wr_on_sample_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> smp_i);
  p_no_read_write_bank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> (rd_bank_i != bank_i));
endmodule

// File: rtl/nts_cmem.sv
`timescale 1ns/1ps
module nts_cmem
  import nts_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_OUT = 4,
  parameter int SLOTS = 64,
  localparam int IN_W   = $clog2(N_IN),
  localparam int OUT_W  = $clog2(N_OUT),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int LOG_W  = OUT_W,
  localparam int DATA_W = IN_W + SLOT_W,
  localparam int ADDR_W = 1 + OUT_W + SLOT_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic [SLOT_W-1:0]            lk_slot_i,
  output logic [N_OUT-1:0][IN_W-1:0]   rd_st_o,
  output logic [N_OUT-1:0][SLOT_W-1:0] rd_sl_o
);
  logic [DATA_W-1:0]          cm_q [N_OUT][SLOTS];
  logic [N_OUT-1:0][IN_W-1:0] sel_q;
  mode_e                      mode_q;

  logic              is_ctl, sel_hit;
  logic [OUT_W-1:0]  cm_o;
  logic [SLOT_W-1:0] cm_s;
  logic [LOG_W-1:0]  sel_idx;

  assign is_ctl  = addr_i[ADDR_W-1];
  assign cm_o    = addr_i[ADDR_W-2 -: OUT_W];
  assign cm_s    = addr_i[SLOT_W-1:0];
  assign sel_hit = addr_i[LOG_W];
  assign sel_idx = addr_i[LOG_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int o = 0; o < N_OUT; o++)
        for (int s = 0; s < SLOTS; s++) cm_q[o][s] <= '0;
      for (int k = 0; k < N_OUT; k++) sel_q[k] <= IN_W'(k);
      mode_q <= MODE_BLOCK;
    end else if (wr_en_i) begin
      if (!is_ctl)      cm_q[cm_o][cm_s] <= wdata_i;
      else if (sel_hit) sel_q[sel_idx]   <= wdata_i[IN_W-1:0];
      else              mode_q           <= mode_e'(wdata_i[0]);
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_lk
    logic [DATA_W-1:0] ent;
    logic [IN_W-1:0]   src;
    assign ent        = cm_q[o][lk_slot_i];
    assign src        = ent[DATA_W-1 -: IN_W];
    assign rd_sl_o[o] = ent[SLOT_W-1:0];
    // non-blocking: low source bits pick a logical input, the table gives the stream
    assign rd_st_o[o] = (mode_q == MODE_NONBLOCK) ? sel_q[src[LOG_W-1:0]] : src;
  end

  p_mode_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && is_ctl && !sel_hit) |=>
      (mode_q == ($past(wdata_i[0]) ? MODE_NONBLOCK : MODE_BLOCK)));
  p_sel_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && is_ctl && sel_hit) |=> (sel_q[$past(sel_idx)] == $past(wdata_i[IN_W-1:0])));
  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(mode_q) && $stable(sel_q)));
  p_cm_keeps_ctl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !is_ctl) |=> ($stable(mode_q) && $stable(sel_q)));
endmodule

// File: rtl/nts_tx.sv
`timescale 1ns/1ps
module nts_tx
  import nts_pkg::*;
#(
  parameter int N_OUT = 4,
  localparam int NB_W = $clog2(NIB_W)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        pref_i,
  input  logic [N_OUT-1:0][NIB_W-1:0] nib_i,
  input  logic [NB_W-1:0]             nbit_i,
  output logic [N_OUT-1:0]            sto_o
);
  logic [N_OUT-1:0][NIB_W-1:0] nib_q;
  logic [NB_W-1:0]             msb_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     nib_q <= '0;
    else if (pref_i) nib_q <= nib_i;
  end

  assign msb_idx = ~nbit_i;
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign sto_o[o] = nib_q[o][msb_idx];
  end

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pref_i |=> $stable(nib_q));
  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pref_i |=> (nib_q == $past(nib_i)));
endmodule

// File: rtl/nibble_tsi.sv
`timescale 1ns/1ps
module nibble_tsi
  import nts_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_OUT = 4,
  parameter int SLOTS = 64,
  localparam int IN_W   = $clog2(N_IN),
  localparam int OUT_W  = $clog2(N_OUT),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int NB_W   = $clog2(NIB_W),
  localparam int DATA_W = IN_W + SLOT_W,
  localparam int ADDR_W = 1 + OUT_W + SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fp_i,
  input  logic [N_IN-1:0]   sti_i,
  output logic [N_OUT-1:0]  sto_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i
);
  logic                         bank, smp, wr, pref, pref_bank;
  logic [SLOT_W-1:0]            slot, pref_slot;
  logic [NB_W-1:0]              nbit;
  logic [N_OUT-1:0][IN_W-1:0]   rd_st;
  logic [N_OUT-1:0][SLOT_W-1:0] rd_sl;
  logic [N_OUT-1:0][NIB_W-1:0]  rd_nib;

  nts_frame_ctr #(.SLOTS(SLOTS)) u_ctr (
    .clk_i, .rst_ni, .fp_i,
    .bank_o(bank), .smp_o(smp), .wr_o(wr), .slot_o(slot), .nbit_o(nbit),
    .pref_o(pref), .pref_slot_o(pref_slot), .pref_bank_o(pref_bank)
  );

  nts_cmem #(.N_IN(N_IN), .N_OUT(N_OUT), .SLOTS(SLOTS)) u_cmem (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .lk_slot_i(pref_slot), .rd_st_o(rd_st), .rd_sl_o(rd_sl)
  );

  nts_rx #(.N_IN(N_IN), .N_OUT(N_OUT), .SLOTS(SLOTS)) u_rx (
    .clk_i, .rst_ni, .sti_i, .smp_i(smp), .wr_i(wr), .bank_i(bank), .slot_i(slot),
    .rd_bank_i(pref_bank), .rd_st_i(rd_st), .rd_sl_i(rd_sl), .rd_nib_o(rd_nib)
  );

  nts_tx #(.N_OUT(N_OUT)) u_tx (
    .clk_i, .rst_ni, .pref_i(pref), .nib_i(rd_nib), .nbit_i(nbit), .sto_o
  );
endmodule

// File: tb/tb_nibble_tsi.sv
`timescale 1ns/1ps
module tb_nibble_tsi;
  localparam int NV = 10;
  localparam int WD_CYC = 150000;
  // {nb, out[1:0], out_slot[5:0], src[2:0], src_slot[5:0]}
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 2'd0, 6'd5,  3'd7, 6'd40},
    {1'b0, 2'd3, 6'd63, 3'd1, 6'd63},
    {1'b0, 2'd1, 6'd0,  3'd6, 6'd0},
    {1'b0, 2'd2, 6'd31, 3'd4, 6'd12},
    {1'b1, 2'd0, 6'd9,  3'd1, 6'd20},
    {1'b1, 2'd1, 6'd10, 3'd6, 6'd33},
    {1'b1, 2'd2, 6'd62, 3'd3, 6'd1},
    {1'b1, 2'd3, 6'd0,  3'd4, 6'd63},
    {1'b0, 2'd2, 6'd17, 3'd5, 6'd17},
    {1'b0, 2'd0, 6'd5,  3'd2, 6'd40}
  };
  localparam int SEL [4] = '{5, 2, 7, 3};

  logic       clk = 1'b0, rst_ni = 1'b0, fp = 1'b0, wr_en = 1'b0, start = 1'b0;
  logic [7:0] sti = '0;
  logic [3:0] sto;
  logic [8:0] addr = '0, wdata = '0;

  int n_chk = 0, n_fail = 0, ncap = 0, capf = 0, fin = 0, ph = 0, hold_err = 0, zero_err = 0;
  logic [3:0] cur [4][64];
  logic [3:0] cap [4][64];
  logic [3:0] prev_sto;

  always #10 clk = ~clk;

  nibble_tsi dut (
    .clk_i(clk), .rst_ni(rst_ni), .fp_i(fp), .sti_i(sti), .sto_o(sto),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata)
  );

  function automatic logic [3:0] pat(int f, int st, int sl);
    return 4'((f * 5 + st * 7 + sl * 3 + 1) & 15);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic wr(input logic [8:0] a, input logic [8:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic wait_caps(input int n);
    int t;
    t = ncap + n;
    while (ncap < t) @(negedge clk);
  endtask

  // serial driver and capture, one pass per clock at the falling edge
  initial begin
    wait (start);
    forever begin
      int b, sl;
      b  = ph >> 1;
      sl = b >> 2;
      if (ph[0] == 1'b0) begin
        for (int o = 0; o < 4; o++) cur[o][sl][3 - (b & 3)] = sto[o];
        prev_sto = sto;
      end else if (sto != prev_sto) begin
        hold_err++;
      end
      if (fin == 0 && ph < 7 && sto != 4'h0) zero_err++;
      for (int st = 0; st < 8; st++) sti[st] = pat(fin, st, sl)[3 - (b & 3)];
      fp = (ph == 511);
      if (ph == 511) begin
        for (int o = 0; o < 4; o++)
          for (int s = 0; s < 64; s++) cap[o][s] = cur[o][s];
        capf = fin;
        fin++;
        ncap++;
        ph = 0;
      end else begin
        ph++;
      end
      @(negedge clk);
    end
  end

  initial begin
    #(WD_CYC * 20);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    start  = 1'b1;

    // R1: reset state
    wait_caps(2);
    chk(zero_err == 0, "R1 outputs zero after reset", zero_err, 0);
    for (int o = 0; o < 4; o++) begin
      int bad;
      bad = 0;
      for (int s = 0; s < 64; s++) if (cap[o][s] != pat(capf - 1, 0, 0)) bad++;
      chk(bad == 0, "R1 default entries copy stream0 slot0", bad, 0);
    end

    // R6: load the input table
    for (int k = 0; k < 4; k++) wr({1'b1, 5'd0, 1'b1, 2'(k)}, 9'(SEL[k]));

    // R3 R5 R10: vector table
    for (int v = 0; v < NV; v++) begin
      logic nb;
      int o, os, src, ss, phys;
      nb  = VEC[v][17];
      o   = int'(VEC[v][16:15]);
      os  = int'(VEC[v][14:9]);
      src = int'(VEC[v][8:6]);
      ss  = int'(VEC[v][5:0]);
      phys = nb ? SEL[src & 3] : src;
      wr(9'h100, {8'd0, nb});
      wr({1'b0, 2'(o), 6'(os)}, {3'(src), 6'(ss)});
      wait_caps(2);
      chk(cap[o][os] == pat(capf - 1, phys, ss),
          nb ? "R5 R6 non-blocking vector" : "R3 R10 blocking vector",
          int'(cap[o][os]), int'(pat(capf - 1, phys, ss)));
    end

    // R7: one source feeding two outputs
    wr({1'b0, 2'd1, 6'd2}, {3'd3, 6'd44});
    wr({1'b0, 2'd3, 6'd50}, {3'd3, 6'd44});
    wait_caps(2);
    chk(cap[1][2] == pat(capf - 1, 3, 44), "R7 broadcast out1", int'(cap[1][2]), int'(pat(capf - 1, 3, 44)));
    chk(cap[3][50] == pat(capf - 1, 3, 44), "R7 broadcast out3", int'(cap[3][50]), int'(pat(capf - 1, 3, 44)));

    // R9: address and data toggled with the strobe low
    @(negedge clk);
    addr = {1'b0, 2'd0, 6'd5}; wdata = {3'd6, 6'd3};
    @(negedge clk);
    addr = 9'h100; wdata = 9'd1;
    @(negedge clk);
    addr = '0; wdata = '0;
    wait_caps(2);
    chk(cap[0][5] == pat(capf - 1, 2, 40), "R9 idle port keeps entry", int'(cap[0][5]), int'(pat(capf - 1, 2, 40)));
    chk(cap[0][9] == pat(capf - 1, 1, 20), "R9 idle port keeps blocking mode", int'(cap[0][9]), int'(pat(capf - 1, 1, 20)));

    // R4: every bit held over both of its clocks
    chk(hold_err == 0, "R4 bit held two clocks", hold_err, 0);

    summary();
    $finish;
  end
endmodule